// File: doc/BRIEF.md
# Response Flit Packer with Zero-Data Compression

This block sits between a target's response port and a 33-bit on-chip network. It takes response flits on a valid/ready interface and re-emits them as network flits on a second valid/ready interface. Each outgoing packet opens with a header flit that carries the initiator identifier, the error status, the transaction number and the packet type tag. Bit 32 of every network flit marks the end of the packet.

A response that is one flit long and whose data word is zero has nothing useful in its payload. Write acknowledgements and successful conditional-store or swap results are of this kind. Such a response is sent as a single header flit with the end mark set. Any other response of N flits is sent as a header followed by N data flits. The block therefore holds the first input flit in a register until it knows the packet length. After the header it replays that held flit, and the remaining flits then pass straight through.

Top module: `rsp_flit_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The header flit holds the source id in bits 31:18, the error field in bits 17:16, the transaction number in bits 15:12 and the type tag in bits 11:8. Bits 7:0 are zero, including bit 0, the broadcast bit.
- R3: A response of one flit with data 0 produces exactly one flit: the header, with bit 32 set to 1.
- R4: A response of one flit with non-zero data produces two flits: the header with bit 32 = 0, then the data in bits 31:0 with bit 32 = 1.
- R5: A response of N > 1 flits produces N+1 flits: the header, then the data words in input order. Only the last flit has bit 32 = 1, and this holds even when the first word is zero.
- R6: The single-bit input error goes to header bit 16. Header bit 17 is always 0.
- R7: in_ready is 0 while a header is waiting to be sent.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_flit stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Response flit offered |
| in_ready | output | 1 | Response flit taken |
| in_data | input | 32 | Response data word |
| in_eop | input | 1 | Last flit of the response |
| in_srcid | input | 14 | Initiator identifier |
| in_err | input | 1 | Error status |
| in_trdid | input | 4 | Transaction number |
| in_pktid | input | 4 | Packet type tag |
| out_valid | output | 1 | Network flit offered |
| out_ready | input | 1 | Network flit taken |
| out_flit | output | 33 | Network flit, bit 32 is end of packet |

## Verification
Two things are decided on the same input flit: whether the packet is compressed and where it ends. A single-flit response must end at the header when its data is zero, and at the replayed data flit otherwise. The bench provokes both outcomes with one-flit responses of zero and non-zero data. It also sends multi-flit responses whose first word is zero, which must not be compressed. Every packet runs under full, alternating and irregular output backpressure. A scoreboard judges the result by the exact flit sequence and the position of the end mark, and it also checks that the input stays stalled while each header is pending.

// File: rtl/rsp_pack_pkg.sv
package rsp_pack_pkg;
    localparam int DATA_W_DEF  = 32;
    localparam int SRCID_W_DEF = 14;
    localparam int TRDID_W_DEF = 4;
    localparam int PKTID_W_DEF = 4;
    localparam int ERR_W_DEF   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HDR    = 2'd1,
        ST_REPLAY = 2'd2,
        ST_STREAM = 2'd3
    } pk_state_e;
endpackage

// File: rtl/rsp_hdr_fmt.sv
module rsp_hdr_fmt #(
    parameter int DATA_W  = rsp_pack_pkg::DATA_W_DEF,
    parameter int SRCID_W = rsp_pack_pkg::SRCID_W_DEF,
    parameter int TRDID_W = rsp_pack_pkg::TRDID_W_DEF,
    parameter int PKTID_W = rsp_pack_pkg::PKTID_W_DEF,
    parameter int ERR_W   = rsp_pack_pkg::ERR_W_DEF
) (
    input  logic               eop,
    input  logic [SRCID_W-1:0] srcid,
    input  logic               err,
    input  logic [TRDID_W-1:0] trdid,
    input  logic [PKTID_W-1:0] pktid,
    output logic [DATA_W:0]    hdr_flit
);
    localparam int RES_W = DATA_W - SRCID_W - ERR_W - TRDID_W - PKTID_W - 1;

    // Header layout from the top down: id, widened error, transaction, tag,
    // reserved zeros, broadcast bit (always clear on responses).
    always_comb begin
        hdr_flit = {eop, srcid, {(ERR_W-1){1'b0}}, err, trdid, pktid,
                    {RES_W{1'b0}}, 1'b0};
    end
endmodule

// File: rtl/rsp_pack_fsm.sv
module rsp_pack_fsm
    import rsp_pack_pkg::*;
#(
    parameter int DATA_W  = DATA_W_DEF,
    parameter int SRCID_W = SRCID_W_DEF,
    parameter int TRDID_W = TRDID_W_DEF,
    parameter int PKTID_W = PKTID_W_DEF,
    parameter int ERR_W   = ERR_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_eop,
    input  logic [SRCID_W-1:0] in_srcid,
    input  logic               in_err,
    input  logic [TRDID_W-1:0] in_trdid,
    input  logic [PKTID_W-1:0] in_pktid,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W:0]    out_flit,
    input  logic [DATA_W:0]    hdr_flit,
    output logic               cap_cmp,
    output logic [SRCID_W-1:0] cap_srcid,
    output logic               cap_err,
    output logic [TRDID_W-1:0] cap_trdid,
    output logic [PKTID_W-1:0] cap_pktid
);
    localparam int FLIT_W = DATA_W + 1;
    localparam int RES_W  = DATA_W - SRCID_W - ERR_W - TRDID_W - PKTID_W - 1;
    localparam int ERR_HI = RES_W + 1 + PKTID_W + TRDID_W + ERR_W - 1;

    typedef struct packed {
        pk_state_e          state;
        logic [DATA_W-1:0]  data;
        logic               eop;
        logic               cmp;
        logic [SRCID_W-1:0] srcid;
        logic               err;
        logic [TRDID_W-1:0] trdid;
        logic [PKTID_W-1:0] pktid;
    } pk_regs_t;

    pk_regs_t q, d;

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_flit  = '0;
        case (q.state)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.data  = in_data;
                    d.eop   = in_eop;
                    d.cmp   = in_eop && (in_data == '0);
                    d.srcid = in_srcid;
                    d.err   = in_err;
                    d.trdid = in_trdid;
                    d.pktid = in_pktid;
                    d.state = ST_HDR;
                end
            end
            ST_HDR: begin
                out_valid = 1'b1;
                out_flit  = hdr_flit;
                if (out_ready) begin
                    d.state = q.cmp ? ST_IDLE : ST_REPLAY;
                end
            end
            ST_REPLAY: begin
                out_valid = 1'b1;
                out_flit  = {q.eop, q.data};
                if (out_ready) begin
                    d.state = q.eop ? ST_IDLE : ST_STREAM;
                end
            end
            default: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_flit  = {in_eop, in_data};
                if (in_valid && out_ready && in_eop) begin
                    d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cap_cmp   = q.cmp;
    assign cap_srcid = q.srcid;
    assign cap_err   = q.err;
    assign cap_trdid = q.trdid;
    assign cap_pktid = q.pktid;

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));

    // R7
    hdr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HDR) |-> !in_ready);

    // R3
    compress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && q.state == ST_HDR && out_flit[FLIT_W-1])
            |-> (q.eop && q.data == '0));

    // R6
    hdr_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HDR) |-> (!out_flit[ERR_HI] && out_flit[RES_W:0] == '0));

    // R5
    eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_flit[FLIT_W-1]) |=> (in_ready && !out_valid));
endmodule

// File: rtl/rsp_flit_packer.sv
module rsp_flit_packer #(
    parameter int DATA_W  = rsp_pack_pkg::DATA_W_DEF,
    parameter int SRCID_W = rsp_pack_pkg::SRCID_W_DEF,
    parameter int TRDID_W = rsp_pack_pkg::TRDID_W_DEF,
    parameter int PKTID_W = rsp_pack_pkg::PKTID_W_DEF,
    parameter int ERR_W   = rsp_pack_pkg::ERR_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_eop,
    input  logic [SRCID_W-1:0] in_srcid,
    input  logic               in_err,
    input  logic [TRDID_W-1:0] in_trdid,
    input  logic [PKTID_W-1:0] in_pktid,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W:0]    out_flit
);
    logic [DATA_W:0]    hdr_flit;
    logic               cap_cmp;
    logic [SRCID_W-1:0] cap_srcid;
    logic               cap_err;
    logic [TRDID_W-1:0] cap_trdid;
    logic [PKTID_W-1:0] cap_pktid;

    rsp_hdr_fmt #(
        .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W),
        .PKTID_W(PKTID_W), .ERR_W(ERR_W)
    ) u_hdr (
        .eop(cap_cmp), .srcid(cap_srcid), .err(cap_err),
        .trdid(cap_trdid), .pktid(cap_pktid), .hdr_flit(hdr_flit)
    );

    rsp_pack_fsm #(
        .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRDID_W(TRDID_W),
        .PKTID_W(PKTID_W), .ERR_W(ERR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_eop(in_eop), .in_srcid(in_srcid), .in_err(in_err),
        .in_trdid(in_trdid), .in_pktid(in_pktid),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .hdr_flit(hdr_flit),
        .cap_cmp(cap_cmp), .cap_srcid(cap_srcid), .cap_err(cap_err),
        .cap_trdid(cap_trdid), .cap_pktid(cap_pktid)
    );
endmodule

// File: tb/rsp_flit_packer_tb.sv
module rsp_flit_packer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_eop = 1'b0;
    logic [13:0] in_srcid = '0;
    logic        in_err = 1'b0;
    logic [3:0]  in_trdid = '0;
    logic [3:0]  in_pktid = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [32:0] out_flit;

    int n_tests = 0;
    int n_fail  = 0;
    int rmode   = 0;
    int cyc     = 0;
    logic [31:0] words [0:15];
    logic [32:0] expq [$];
    string       tagq [$];
    logic        hdrq [$];
    logic        prev_stall = 1'b0;
    logic [32:0] prev_flit  = '0;
    logic        hdr_seen   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsp_flit_packer u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_eop(in_eop), .in_srcid(in_srcid), .in_err(in_err),
        .in_trdid(in_trdid), .in_pktid(in_pktid),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Driver: pushes expected flits, then offers the response flits.
    task automatic send_pkt(input logic [13:0] sid, input logic err,
                            input logic [3:0] tid, input logic [3:0] pid, input int n);
        logic cmp;
        cmp = (n == 1) && (words[0] == 32'h0);
        expq.push_back({cmp, sid, 1'b0, err, tid, pid, 7'b0, 1'b0});
        tagq.push_back(cmp ? "R3" : (err ? "R6" : "R2"));
        hdrq.push_back(1'b1);
        if (!cmp) begin
            for (int k = 0; k < n; k++) begin
                expq.push_back({(k == n-1), words[k]});
                tagq.push_back(n == 1 ? "R4" : "R5");
                hdrq.push_back(1'b0);
            end
        end
        for (int k = 0; k < n; k++) begin
            in_valid = 1'b1;
            in_data  = words[k];
            in_eop   = (k == n-1);
            in_srcid = sid;
            in_err   = err;
            in_trdid = tid;
            in_pktid = pid;
            forever begin
                @(negedge clk);
                #2;
                if (in_ready) begin
                    @(posedge clk);
                    #1;
                    break;
                end
            end
        end
        in_valid = 1'b0;
        in_data  = '0;
        in_eop   = 1'b0;
    endtask

    // Monitor: chooses backpressure, then compares against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (rmode)
                0: out_ready = 1'b1;
                1: out_ready = cyc[0];
                default: out_ready = ($urandom % 4) != 0;
            endcase
            #1;
            if (rst_n) begin
                if (prev_stall) begin
                    chk("R8", {out_valid, out_flit}, {1'b1, prev_flit});
                end
                if (out_valid && hdrq.size() > 0 && hdrq[0] && !hdr_seen) begin
                    chk("R7", {32'h0, in_ready}, 33'h0);
                    hdr_seen = 1'b1;
                end
                if (out_valid && out_ready) begin
                    if (expq.size() == 0) begin
                        chk("R5", out_flit, 33'h1_FFFF_FFFF ^ out_flit);
                    end else begin
                        chk(tagq[0], out_flit, expq[0]);
                        void'(expq.pop_front());
                        void'(tagq.pop_front());
                        void'(hdrq.pop_front());
                        hdr_seen = 1'b0;
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_flit  = out_flit;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog expired, %0d flits still expected", expq.size());
        summary();
        $finish;
    end

    task automatic run_set(input int base);
        // R3: write acknowledge
        words[0] = 32'h0;
        send_pkt(14'h0001 + 14'(base), 1'b0, 4'h3, 4'h4, 1);
        // R4: failed conditional store
        words[0] = 32'h1;
        send_pkt(14'h2A55, 1'b0, 4'h1, 4'h7, 1);
        // R5: linked load, signature then data
        words[0] = 32'hCAFE_0001 + 32'(base);
        words[1] = 32'h1234_5678;
        send_pkt(14'h3FFF, 1'b0, 4'hF, 4'hF, 2);
        // R5: multi-flit whose first word is zero
        words[0] = 32'h0;
        words[1] = 32'h0;
        words[2] = 32'hDEAD_BEEF;
        send_pkt(14'h0100, 1'b0, 4'h2, 4'h1, 3);
        // R6: error response, zero data, compressed
        words[0] = 32'h0;
        send_pkt(14'h1555, 1'b1, 4'hA, 4'h0, 1);
        // R6 + R5: full read burst with error
        for (int k = 0; k < 16; k++) words[k] = 32'hA500_0000 + 32'(k) * 32'h0101_0101;
        send_pkt(14'h0ABC, 1'b1, 4'h5, 4'h2, 16);
        // R4: non-zero single word with error
        words[0] = 32'h8000_0000;
        send_pkt(14'h0000, 1'b1, 4'h0, 4'h5, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1
        chk("R1", {31'h0, out_valid, in_ready}, {31'h0, 1'b0, 1'b1});
        @(posedge clk);
        #1;
        rmode = 0;
        run_set(0);
        rmode = 1;
        run_set(1);
        rmode = 2;
        for (int r = 0; r < 4; r++) run_set(r + 2);
        while (expq.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        summary();
        $finish;
    end
endmodule